// File: doc/BRIEF.md
# ADC Result Block Transfer Controller

This block copies each fresh conversion result from an analog-to-digital converter into system memory without processor help. On every result-ready pulse it issues one 16-bit word write on a plain write port and moves its address pointer forward by two bytes. Software configures a per-block transfer count, a start address, a two-block (ping-pong) select and a continuous select. The controller counts transfers and raises an interrupt flag whenever a block has been filled. A status bit tells software which of the two blocks was filled last.

The sequencer has three named states. FILL_FIRST fills block one. FILL_SECOND fills block two and is entered only in two-block mode. HALTED ignores results. The transitions are as follows. Block end in FILL_FIRST goes to FILL_SECOND when two-block mode is on. A final-block end goes to FILL_FIRST with an address reload when continuous mode is on, and to HALTED when it is off. A start-address write goes from any state to FILL_FIRST. A transfer count of zero freezes the engine in whatever state it holds.

Each write port output is registered, so a write appears in the clock cycle after the result pulse. The start address register, the pointer and the transfer counter are all internal.

Top module: `adc_xfer_ctrl`

## Requirements
- R1: After reset the start address is 0x200, the state is FILL_FIRST with zero transfers done, `mem_we` is 0, `irq_flag` is 0 and `last_blk` is 0; the first accepted result is written to 0x200.
- R2: Each accepted `res_valid` pulse produces exactly one write in the following cycle: `mem_we`=1 for that cycle, with `mem_wdata` equal to the sampled `res_data`.
- R3: Successive writes within a run go to addresses that each exceed the previous one by 2, and this holds across the boundary from block one to block two.
- R4: While `cfg_count` is 0, `res_valid` is ignored: no write occurs, and neither the address nor the transfer count advances.
- R5: With `cfg_two_block`=0 and `cfg_continuous`=0, the controller enters HALTED after `cfg_count` writes. Later results produce no write until the start address is written again.
- R6: With `cfg_two_block`=1 and `cfg_continuous`=0, the controller makes 2×`cfg_count` writes at linear addresses and then enters HALTED.
- R7: With `cfg_two_block`=0 and `cfg_continuous`=1, the write after each completed block goes to the start address again, without end.
- R8: With `cfg_two_block`=1 and `cfg_continuous`=1, the write after the second block completes goes to the start address again, and the next block filled is block one.
- R9: The stop-or-wrap decision uses `cfg_continuous` at the moment the final block completes. If the bit is cleared during a run, the controller halts at the end of the current final block.
- R10: A `sa_wr` pulse loads `sa_wdata` into the start address and the pointer, clears the transfer count, enters FILL_FIRST (this also leaves HALTED), and discards any `res_valid` in the same cycle.
- R11: `irq_flag` is set in the same cycle as the write that completes a block, and never on a write in mid-block. It holds until `irq_clr` is asserted. A set and a clear in the same cycle leave the flag at 1.
- R12: `last_blk` is 0 when block one most recently completed and 1 when block two did. It updates with `irq_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_count | input | 8 | Transfers per block; 0 disables the engine |
| cfg_two_block | input | 1 | 1 = fill two consecutive blocks |
| cfg_continuous | input | 1 | 1 = wrap to start address after final block |
| sa_wr | input | 1 | Start address write strobe |
| sa_wdata | input | 16 | New start address |
| irq_clr | input | 1 | Clear strobe for the interrupt flag |
| res_valid | input | 1 | One-cycle result-ready pulse |
| res_data | input | 16 | Conversion result |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| irq_flag | output | 1 | Block-complete interrupt flag |
| last_blk | output | 1 | 0 = block one, 1 = block two most recently completed |

## Verification
The bench first applies a count of zero and then a valid count, and checks that the first write still lands at 0x200. A design whose counters ran while disabled would write to a later address. It also checks the 2×count boundary in two-block mode and the wrap points in both continuous modes. A design that reloaded after block one, or never reloaded, would write to the wrong address. Further cases are a start-address write in mid-block and a start-address write that coincides with a result: a wrong design would keep the old transfer count and flag early, or write the dropped result. Clearing the continuous bit during a run must halt the controller at the end of the final block. An interrupt clear that coincides with a block end must leave the flag set.

// File: rtl/adc_xfer_pkg.sv
package adc_xfer_pkg;
    typedef enum logic [1:0] {
        ST_FILL_FIRST  = 2'd0,
        ST_FILL_SECOND = 2'd1,
        ST_HALTED      = 2'd2
    } xfer_state_e;
endpackage

// File: rtl/xfer_addr_gen.sv
module xfer_addr_gen #(
    parameter int ADDR_W   = 16,
    parameter int STEP     = 2,
    parameter int SA_RESET = 'h200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sa_wr,
    input  logic [ADDR_W-1:0] sa_wdata,
    input  logic              step,
    input  logic              reload,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] START_RST = ADDR_W'(SA_RESET);
    localparam logic [ADDR_W-1:0] INC       = ADDR_W'(STEP);

    logic [ADDR_W-1:0] start_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= START_RST;
            ptr     <= START_RST;
        end else if (sa_wr) begin
            start_q <= sa_wdata;
            ptr     <= sa_wdata;
        end else if (reload) begin
            ptr     <= start_q;
        end else if (step) begin
            ptr     <= ptr + INC;
        end
    end

    // R10: a start-address write lands in the pointer
    a_r10_sa_load: assert property (@(posedge clk) disable iff (!rst_n)
        sa_wr |=> ptr == $past(sa_wdata));

    // R3: a plain step moves the pointer by one word
    a_r3_step_two: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !sa_wr && !reload) |=> ptr == $past(ptr) + INC);
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
    import adc_xfer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             cfg_two_block,
    input  logic             cfg_continuous,
    input  logic             sa_wr,
    input  logic             res_valid,
    output logic             fire,
    output logic             blk_end,
    output logic             blk_is_second,
    output logic             step,
    output logic             reload
);
    xfer_state_e      state_q, state_d;
    logic [CNT_W-1:0] idx_q, idx_d;
    logic             armed, final_blk;
    logic [CNT_W:0]   idx_next;

    assign armed     = (state_q != ST_HALTED) && (cfg_count != '0);
    assign fire      = res_valid && !sa_wr && armed;
    assign idx_next  = {1'b0, idx_q} + 1'b1;
    assign blk_end   = fire && (idx_next >= {1'b0, cfg_count});
    assign final_blk = (state_q == ST_FILL_SECOND) || !cfg_two_block;
    assign blk_is_second = (state_q == ST_FILL_SECOND);
    assign reload    = blk_end && final_blk && cfg_continuous;
    assign step      = fire && !reload;

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        if (sa_wr) begin
            state_d = ST_FILL_FIRST;
            idx_d   = '0;
        end else if (fire) begin
            idx_d = idx_next[CNT_W-1:0];
            if (blk_end) begin
                idx_d = '0;
                unique case (state_q)
                    ST_FILL_FIRST:
                        if (cfg_two_block)       state_d = ST_FILL_SECOND;
                        else if (cfg_continuous) state_d = ST_FILL_FIRST;
                        else                     state_d = ST_HALTED;
                    ST_FILL_SECOND:
                        if (cfg_continuous)      state_d = ST_FILL_FIRST;
                        else                     state_d = ST_HALTED;
                    default:                     state_d = ST_HALTED;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL_FIRST;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // R5: the halted state is left only through a start-address write
    a_r5_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALTED && !sa_wr) |=> state_q == ST_HALTED);

    // R10: a start-address write always re-enters block one
    a_r10_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        sa_wr |=> (state_q == ST_FILL_FIRST && idx_q == '0));
endmodule

// File: rtl/xfer_irq.sv
module xfer_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic set_second,
    input  logic clr,
    output logic flag,
    output logic which
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag  <= 1'b0;
            which <= 1'b0;
        end else if (set) begin
            flag  <= 1'b1;
            which <= set_second;
        end else if (clr) begin
            flag  <= 1'b0;
        end
    end

    // R11: set has priority over clear
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
endmodule

// File: rtl/adc_xfer_ctrl.sv
module adc_xfer_ctrl #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int CNT_W    = 8,
    parameter int STEP     = 2,
    parameter int SA_RESET = 'h200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              cfg_two_block,
    input  logic              cfg_continuous,
    input  logic              sa_wr,
    input  logic [ADDR_W-1:0] sa_wdata,
    input  logic              irq_clr,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              irq_flag,
    output logic              last_blk
);
    logic              fire, blk_end, blk_second, step, reload;
    logic [ADDR_W-1:0] ptr;

    xfer_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_count(cfg_count), .cfg_two_block(cfg_two_block),
        .cfg_continuous(cfg_continuous), .sa_wr(sa_wr), .res_valid(res_valid),
        .fire(fire), .blk_end(blk_end), .blk_is_second(blk_second),
        .step(step), .reload(reload)
    );

    xfer_addr_gen #(.ADDR_W(ADDR_W), .STEP(STEP), .SA_RESET(SA_RESET)) u_addr (
        .clk(clk), .rst_n(rst_n), .sa_wr(sa_wr), .sa_wdata(sa_wdata),
        .step(step), .reload(reload), .ptr(ptr)
    );

    xfer_irq u_irq (
        .clk(clk), .rst_n(rst_n), .set(blk_end), .set_second(blk_second),
        .clr(irq_clr), .flag(irq_flag), .which(last_blk)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= fire;
            if (fire) begin
                mem_addr  <= ptr;
                mem_wdata <= res_data;
            end
        end
    end

    // R4: a zero count blocks every write
    a_r4_zero_count_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_count == '0) |=> !mem_we);

    // R11: the flag rises only together with a completing write
    a_r11_flag_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> mem_we);

    // R2: no write without a result pulse in the prior cycle
    a_r2_write_needs_result: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> !mem_we);
endmodule

// File: tb/adc_xfer_ctrl_bench.sv
module adc_xfer_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_count = 8'd0;
    logic        cfg_two_block = 1'b0;
    logic        cfg_continuous = 1'b0;
    logic        sa_wr = 1'b0;
    logic [15:0] sa_wdata = 16'd0;
    logic        irq_clr = 1'b0;
    logic        res_valid = 1'b0;
    logic [15:0] res_data = 16'd0;
    logic        mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic        irq_flag, last_blk;

    int checks = 0;
    int errors = 0;
    logic [15:0] mem [256];

    always #5 clk = ~clk;

    adc_xfer_ctrl u_adc_xfer_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_count(cfg_count),
        .cfg_two_block(cfg_two_block), .cfg_continuous(cfg_continuous),
        .sa_wr(sa_wr), .sa_wdata(sa_wdata), .irq_clr(irq_clr),
        .res_valid(res_valid), .res_data(res_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .irq_flag(irq_flag), .last_blk(last_blk)
    );

    always @(posedge clk) if (mem_we) mem[mem_addr[8:1]] <= mem_wdata;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive a result pulse; sample the write one cycle later
    task automatic push(input logic [15:0] d);
        @(negedge clk); res_valid = 1'b1; res_data = d;
        @(negedge clk); res_valid = 1'b0;
    endtask

    task automatic push_expect(input string req, input logic [15:0] d,
                               input logic [15:0] a, input logic flg);
        push(d);
        chk({req, " we"}, 32'(mem_we), 32'd1);
        chk({req, " addr"}, 32'(mem_addr), 32'(a));
        chk({req, " data"}, 32'(mem_wdata), 32'(d));
        chk({req, " flag"}, 32'(irq_flag), 32'(flg));
    endtask

    task automatic push_none(input string req);
        push(16'hDEAD);
        chk({req, " no write"}, 32'(mem_we), 32'd0);
    endtask

    task automatic write_sa(input logic [15:0] a);
        @(negedge clk); sa_wr = 1'b1; sa_wdata = a;
        @(negedge clk); sa_wr = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset we", 32'(mem_we), 32'd0);
        chk("R1 reset flag", 32'(irq_flag), 32'd0);
        chk("R1 reset last_blk", 32'(last_blk), 32'd0);
    endtask

    task automatic t_disabled_then_one_block();
        cfg_count = 8'd0;
        push_none("R4 count zero");
        push_none("R4 count zero again");
        cfg_count = 8'd3;
        push_expect("R1 R4 first at 0x200", 16'h1111, 16'h0200, 1'b0);
        push_expect("R3 second", 16'h2222, 16'h0202, 1'b0);
        push_expect("R5 R11 block end", 16'h3333, 16'h0204, 1'b1);
        chk("R12 first block", 32'(last_blk), 32'd0);
        push_none("R5 halted");
        chk("R11 flag held", 32'(irq_flag), 32'd1);
        chk("R2 memory content", 32'(mem[8'h01]), 32'h2222);
        clear_irq();
        chk("R11 flag cleared", 32'(irq_flag), 32'd0);
    endtask

    task automatic t_two_block();
        cfg_two_block = 1'b1; cfg_count = 8'd2;
        write_sa(16'h0300);
        push_expect("R6 b1 w0", 16'hA000, 16'h0300, 1'b0);
        push_expect("R6 b1 w1", 16'hA001, 16'h0302, 1'b1);
        chk("R12 block one", 32'(last_blk), 32'd0);
        clear_irq();
        push_expect("R3 R6 b2 w0", 16'hA002, 16'h0304, 1'b0);
        push_expect("R6 b2 w1", 16'hA003, 16'h0306, 1'b1);
        chk("R12 block two", 32'(last_blk), 32'd1);
        push_none("R6 halted after two blocks");
        clear_irq();
    endtask

    task automatic t_cont_one();
        cfg_two_block = 1'b0; cfg_continuous = 1'b1; cfg_count = 8'd2;
        write_sa(16'h0400);
        push_expect("R7 w0", 16'hB000, 16'h0400, 1'b0);
        push_expect("R7 w1", 16'hB001, 16'h0402, 1'b1);
        clear_irq();
        push_expect("R7 wrap", 16'hB002, 16'h0400, 1'b0);
        push_expect("R7 wrap end", 16'hB003, 16'h0402, 1'b1);
        clear_irq();
    endtask

    task automatic t_cont_two_and_stop();
        cfg_two_block = 1'b1; cfg_continuous = 1'b1; cfg_count = 8'd1;
        write_sa(16'h0500);
        push_expect("R8 b1", 16'hC000, 16'h0500, 1'b1);
        chk("R12 b1", 32'(last_blk), 32'd0);
        push_expect("R8 b2", 16'hC001, 16'h0502, 1'b1);
        chk("R12 b2", 32'(last_blk), 32'd1);
        push_expect("R8 wrap to b1", 16'hC002, 16'h0500, 1'b1);
        chk("R8 wrap is block one", 32'(last_blk), 32'd0);
        cfg_continuous = 1'b0;
        push_expect("R9 final block after clear", 16'hC003, 16'h0502, 1'b1);
        push_none("R9 halted");
        clear_irq();
    endtask

    task automatic t_sa_write();
        cfg_two_block = 1'b0; cfg_continuous = 1'b0; cfg_count = 8'd3;
        write_sa(16'h0600);
        push_expect("R10 w0", 16'hD000, 16'h0600, 1'b0);
        write_sa(16'h0700);
        // coincident start write and result: result dropped
        @(negedge clk); sa_wr = 1'b1; sa_wdata = 16'h0710; res_valid = 1'b1; res_data = 16'hD0FF;
        @(negedge clk); sa_wr = 1'b0; res_valid = 1'b0;
        chk("R10 coincident dropped", 32'(mem_we), 32'd0);
        push_expect("R10 restart w0", 16'hD001, 16'h0710, 1'b0);
        push_expect("R10 count cleared w1", 16'hD002, 16'h0712, 1'b0);
        // set and clear in the same cycle
        @(negedge clk); res_valid = 1'b1; res_data = 16'hD003; irq_clr = 1'b1;
        @(negedge clk); res_valid = 1'b0; irq_clr = 1'b0;
        chk("R11 set wins addr", 32'(mem_addr), 32'h0714);
        chk("R11 set wins flag", 32'(irq_flag), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled_then_one_block();
        t_two_block();
        t_cont_one();
        t_cont_two_and_stop();
        t_sa_write();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule